// File: doc/BRIEF.md
# Three-Level Programming Pulse Classifier

This block watches a single pin through two already synchronized comparator bits: one says the pin is above the middle threshold, the other says it is above the upper threshold. The pin idles at the low level. A programming pulse is an excursion away from low that returns to low. The block measures each excursion and, once the pin is back at low, classifies it as a middle-level pulse or an upper-level pulse. It reports the result with a one-cycle strobe.

Excursions are qualified in two ways. The pin must stay elevated for at least `MIN_ACTIVE` clock cycles. It must also have rested at low for at least `MIN_GAP` cycles before the excursion began. A slow rise to the upper level always crosses the middle band first, so the class comes from the longest unbroken run of the upper comparator inside the excursion, not from the first level seen. An excursion that fails either rule is dropped and reported on a separate error strobe. A downstream decoder counts the strobes. Both width limits are cycle counts, and they scale with the clock (40 µs is 2000 cycles at 50 MHz).

Top module: `pulse_classifier`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all three strobes are 0. After reset, the block needs `MIN_GAP` low cycles before it accepts an excursion. An excursion that starts earlier raises `err_pulse_o`.
- R2: The pin counts as elevated when `cmp_mid_i` or `cmp_high_i` is 1. An excursion seen only on `cmp_high_i` is measured like any other.
- R3: An excursion of N consecutive elevated cycles with N >= `MIN_ACTIVE` raises exactly one strobe. The strobe is 1 in the cycle after the first low sample, and never while the pin is still elevated. N equal to `MIN_ACTIVE` is accepted.
- R4: An accepted excursion raises `high_pulse_o` if `cmp_high_i` was 1 for at least `MIN_ACTIVE` consecutive cycles anywhere inside it, including a run that ends on its last elevated cycle. Otherwise it raises `mid_pulse_o`. Upper-comparator runs shorter than `MIN_ACTIVE` are treated as mid.
- R5: An excursion with N < `MIN_ACTIVE` raises `err_pulse_o` for one cycle, at the same point where R3 would place its strobe, and raises no mid or high strobe.
- R6: An excursion that starts after fewer than `MIN_GAP` low cycles raises `err_pulse_o` in the cycle after its first elevated sample. It raises nothing when it ends. Gap counting restarts at its return to low.
- R7: The low cycle that ends an excursion counts toward the gap. A gap of exactly `MIN_GAP` low cycles is accepted.
- R8: At most one of the three strobes is 1 in any cycle. A mid or high strobe never lasts two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_mid_i | input | 1 | Pin above the middle threshold (synchronized) |
| cmp_high_i | input | 1 | Pin above the upper threshold (synchronized) |
| mid_pulse_o | output | 1 | One-cycle strobe: accepted middle-level pulse |
| high_pulse_o | output | 1 | One-cycle strobe: accepted upper-level pulse |
| err_pulse_o | output | 1 | One-cycle strobe: excursion rejected for width or separation |

## Verification
On every cycle, the assertions check three things: the strobes are mutually exclusive, a mid or high strobe only follows a low sample and never repeats in the next cycle, and the run counters stay within their limits. Only the bench scenarios can show that the right class comes out for a given excursion. This covers exact-width boundaries on both limits, an upper run that is one cycle too short, an upper run that ends on the last elevated cycle, excursions seen only on the upper comparator, and rejected excursions that stay silent when they end. Behaviour around reset, including a reset in the middle of an excursion, is also covered only by the bench.

// File: rtl/pcls_pkg.sv
package pcls_pkg;
  typedef enum logic [1:0] {
    PH_GAP    = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_SPOIL  = 2'd2
  } phase_t;
endpackage

// File: rtl/pcls_sat_counter.sv
module pcls_sat_counter #(
  parameter int LIMIT = 2000,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set1_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst)              cnt_o <= '0;
    else if (set1_i)      cnt_o <= W'(1);
    else if (clr_i)       cnt_o <= '0;
    else if (inc_i && cnt_o != LIM) cnt_o <= cnt_o + W'(1);
  end

  // R3 / R5 / R7: run counters saturate at their qualifying limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= LIM);
endmodule

// File: rtl/pcls_ctrl.sv
module pcls_ctrl
  import pcls_pkg::*;
#(
  parameter int MIN_ACTIVE = 2000,
  parameter int MIN_GAP    = 2000,
  parameter int AW         = $clog2(MIN_ACTIVE + 1),
  parameter int GW         = $clog2(MIN_GAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl_i,
  input  logic          hi_i,
  input  logic [AW-1:0] act_cnt_i,
  input  logic [AW-1:0] hi_cnt_i,
  input  logic [GW-1:0] gap_cnt_i,
  output logic          act_set1_o,
  output logic          act_inc_o,
  output logic          hi_set1_o,
  output logic          hi_clr_o,
  output logic          hi_inc_o,
  output logic          gap_set1_o,
  output logic          gap_clr_o,
  output logic          gap_inc_o,
  output logic          mid_o,
  output logic          high_o,
  output logic          err_o
);
  localparam logic [AW-1:0] ACT_LIM = AW'(MIN_ACTIVE);
  localparam logic [GW-1:0] GAP_LIM = GW'(MIN_GAP);

  phase_t ph_q, ph_d;
  logic   hi_ok_q;
  logic   gap_ok, start, ending, long_ok, cls_high, too_soon;

  always_comb begin
    gap_ok   = gap_cnt_i >= GAP_LIM;
    start    = (ph_q == PH_GAP) && lvl_i && gap_ok;
    too_soon = (ph_q == PH_GAP) && lvl_i && !gap_ok;
    ending   = (ph_q == PH_ACTIVE) && !lvl_i;
    long_ok  = act_cnt_i >= ACT_LIM;
    cls_high = hi_ok_q || (hi_cnt_i >= ACT_LIM);

    act_set1_o = start;
    act_inc_o  = (ph_q == PH_ACTIVE) && lvl_i;
    hi_set1_o  = start && hi_i;
    hi_clr_o   = !hi_i;
    hi_inc_o   = (ph_q == PH_ACTIVE) && lvl_i && hi_i;
    gap_set1_o = !lvl_i && (ph_q != PH_GAP);
    gap_clr_o  = (ph_q == PH_GAP) && lvl_i;
    gap_inc_o  = (ph_q == PH_GAP) && !lvl_i;

    ph_d = ph_q;
    unique case (ph_q)
      PH_GAP:    if (lvl_i) ph_d = gap_ok ? PH_ACTIVE : PH_SPOIL;
      PH_ACTIVE: if (!lvl_i) ph_d = PH_GAP;
      PH_SPOIL:  if (!lvl_i) ph_d = PH_GAP;
      default:   ph_d = PH_GAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_GAP;
      hi_ok_q <= 1'b0;
      mid_o   <= 1'b0;
      high_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      if (start)                                         hi_ok_q <= 1'b0;
      else if (ph_q == PH_ACTIVE && hi_cnt_i >= ACT_LIM) hi_ok_q <= 1'b1;
      mid_o   <= ending && long_ok && !cls_high;
      high_o  <= ending && long_ok && cls_high;
      err_o   <= (ending && !long_ok) || too_soon;
    end
  end

  // R8: strobes never overlap
  a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mid_o, high_o, err_o}));

  // R3: a class strobe only follows a low sample
  a_r3_after_low: assert property (@(posedge clk) disable iff (rst)
    (mid_o || high_o) |-> $past(!lvl_i));

  // R8: class strobes last a single cycle
  a_r8_single: assert property (@(posedge clk) disable iff (rst)
    (mid_o || high_o) |=> !(mid_o || high_o));
endmodule

// File: rtl/pulse_classifier.sv
module pulse_classifier #(
  parameter int MIN_ACTIVE = 2000,
  parameter int MIN_GAP    = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_mid_i,
  input  logic cmp_high_i,
  output logic mid_pulse_o,
  output logic high_pulse_o,
  output logic err_pulse_o
);
  localparam int AW = $clog2(MIN_ACTIVE + 1);
  localparam int GW = $clog2(MIN_GAP + 1);

  logic          lvl;
  logic [AW-1:0] act_cnt, hi_cnt;
  logic [GW-1:0] gap_cnt;
  logic act_set1, act_inc, hi_set1, hi_clr, hi_inc, gap_set1, gap_clr, gap_inc;

  // R2: either comparator marks the pin as elevated
  assign lvl = cmp_mid_i | cmp_high_i;

  pcls_sat_counter #(.LIMIT(MIN_ACTIVE), .W(AW)) u_act_cnt (
    .clk(clk), .rst(rst), .set1_i(act_set1), .clr_i(1'b0),
    .inc_i(act_inc), .cnt_o(act_cnt));

  pcls_sat_counter #(.LIMIT(MIN_ACTIVE), .W(AW)) u_hi_cnt (
    .clk(clk), .rst(rst), .set1_i(hi_set1), .clr_i(hi_clr),
    .inc_i(hi_inc), .cnt_o(hi_cnt));

  pcls_sat_counter #(.LIMIT(MIN_GAP), .W(GW)) u_gap_cnt (
    .clk(clk), .rst(rst), .set1_i(gap_set1), .clr_i(gap_clr),
    .inc_i(gap_inc), .cnt_o(gap_cnt));

  pcls_ctrl #(.MIN_ACTIVE(MIN_ACTIVE), .MIN_GAP(MIN_GAP), .AW(AW), .GW(GW)) u_ctrl (
    .clk(clk), .rst(rst), .lvl_i(lvl), .hi_i(cmp_high_i),
    .act_cnt_i(act_cnt), .hi_cnt_i(hi_cnt), .gap_cnt_i(gap_cnt),
    .act_set1_o(act_set1), .act_inc_o(act_inc),
    .hi_set1_o(hi_set1), .hi_clr_o(hi_clr), .hi_inc_o(hi_inc),
    .gap_set1_o(gap_set1), .gap_clr_o(gap_clr), .gap_inc_o(gap_inc),
    .mid_o(mid_pulse_o), .high_o(high_pulse_o), .err_o(err_pulse_o));
endmodule

// File: tb/pulse_classifier_tb_top.sv
module pulse_classifier_tb_top;
  localparam int MA = 4;
  localparam int MG = 5;
  localparam int NV = 11;
  // fields: active len, high start, high len, trailing low, mid-off, exp mid, exp high, exp err
  localparam int VEC [NV][8] = '{
    '{6, 0, 0, 6, 0, 1, 0, 0},   // R3 plain mid
    '{4, 0, 0, 5, 0, 1, 0, 0},   // R3 exact width; trail = MG (R7)
    '{8, 2, 4, 6, 0, 0, 1, 0},   // R4 exact high run, R7 gap of exactly MG
    '{8, 1, 3, 6, 0, 1, 0, 0},   // R4 high run one short -> mid
    '{3, 0, 0, 6, 0, 0, 0, 1},   // R5 short excursion
    '{10,0,10, 6, 0, 0, 1, 0},   // R4 full high
    '{6, 0, 0, 4, 0, 1, 0, 0},   // R3 mid, then too-short gap follows
    '{6, 0, 0, 6, 0, 0, 0, 1},   // R6 separation violation, silent end
    '{9, 5, 4, 6, 0, 0, 1, 0},   // R4 high run ending on last cycle
    '{1, 0, 0, 6, 0, 0, 0, 1},   // R5 single-cycle excursion
    '{5, 0, 5, 6, 1, 0, 1, 0}    // R2 upper comparator only
  };

  logic clk = 1'b0, rst = 1'b1, cm = 1'b0, ch = 1'b0;
  logic mid_s, high_s, err_s;
  int nchk = 0, nerr = 0;
  int t_mid = 0, t_high = 0, t_err = 0;
  bit zero_seen_bad = 1'b0;

  always #10 clk = ~clk;

  pulse_classifier #(.MIN_ACTIVE(MA), .MIN_GAP(MG)) dut_i (
    .clk(clk), .rst(rst), .cmp_mid_i(cm), .cmp_high_i(ch),
    .mid_pulse_o(mid_s), .high_pulse_o(high_s), .err_pulse_o(err_s));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic h);
    cm = m; ch = h;
    @(negedge clk);
    t_mid  += int'(mid_s);
    t_high += int'(high_s);
    t_err  += int'(err_s);
    if (rst && (mid_s || high_s || err_s)) zero_seen_bad = 1'b1;
  endtask

  task automatic clr_tally();
    t_mid = 0; t_high = 0; t_err = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    // R1: strobes quiet during reset while the pin is elevated
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    chk("R1 strobes during reset", int'(zero_seen_bad), 0);
    chk("R1 reset value sum", int'(mid_s) + int'(high_s) + int'(err_s), 0);
    // R1: elevated right after reset violates the post-reset gap
    rst = 1'b0;
    clr_tally();
    step(1'b1, 1'b1);
    chk("R1 first cycle after reset quiet", int'(mid_s | high_s), 0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
    chk("R1 early excursion err", t_err, 1);
    chk("R1 early excursion no class", t_mid + t_high, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      clr_tally();
      for (int i = 0; i < VEC[v][0]; i++) begin
        logic h;
        h = (i >= VEC[v][1]) && (i < VEC[v][1] + VEC[v][2]);
        step(VEC[v][4] == 0, h);
      end
      for (int i = 0; i < VEC[v][3]; i++) step(1'b0, 1'b0);
      chk($sformatf("R3/R4 vec%0d mid count", v), t_mid, VEC[v][5]);
      chk($sformatf("R4 vec%0d high count", v), t_high, VEC[v][6]);
      chk($sformatf("R5/R6 vec%0d err count", v), t_err, VEC[v][7]);
    end

    // R3: strobe timing, one cycle after the first low sample
    clr_tally();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    chk("R3 no strobe while elevated", t_mid + t_high + t_err, 0);
    step(1'b0, 1'b0);
    chk("R3 mid strobe after first low", int'(mid_s), 1);
    step(1'b0, 1'b0);
    chk("R8 mid strobe single cycle", int'(mid_s), 0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);

    // R1: reset in mid-excursion discards it
    clr_tally();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    rst = 1'b1;
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
    chk("R1 reset mid-excursion no class", t_mid + t_high, 0);
    chk("R1 reset mid-excursion err", t_err, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule